// File: doc/BRIEF.md
# Peripheral DMA Channel Engine

A single-channel engine that moves data between memory and a peripheral without the processor touching each word. Software fills in a source address, a destination address, a beat width, a burst shape and a burst count through a small word-addressed register port, then sets the channel's run bit. The engine reads one beat from the source and writes it to the destination, over and over, on a simple request/ready memory bus. Either address can be held fixed, which is how the peripheral's data port is addressed. The other address steps by the beat width.

Before each burst the engine waits for the peripheral to ask for data, and answers with a one-cycle acknowledge. A self-start mode skips this wait for memory-to-memory moves. Software can pause at a beat boundary and resume later, or abort by clearing the run bit. The live address registers can be read at any time, so the bytes moved so far are the current address minus the start address. A stop code in the second control word records why the channel stopped, and the interrupt line reflects that code through two enable bits.

Top module: `pdma_channel`

## Requirements
- R1: Register words sit at byte offsets 0x00 (global, run-permit at bit 31), 0x10 (control A), 0x14 (control B), 0x18 (source address) and 0x1C (destination address). After reset every word reads zero, `irq` is low, and no memory or acknowledge activity occurs.
- R2: A write that sets control A bit 31 starts the channel only while the global run-permit is 1. Otherwise control A bit 31 reads back 0 and no memory request follows.
- R3: Before each burst the engine waits for `per_req` and pulses `per_ack` for one cycle when it takes the request. It makes no memory access while it waits. When control A bit 29 (self-start) is set, the engine ignores `per_req` and never raises `per_ack`.
- R4: Control A bits 23:20 set the burst length: 0xF gives 16 beats, 0xD gives 8 beats, 0xB gives 4 beats, and any other code gives 1 beat. Bits 15:0 hold the burst count minus one, so a run moves (count+1) bursts.
- R5: Control B bits 27:26 set the beat width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. An address steps by the width after every beat, unless it is held: bit 25 holds the source and bit 24 holds the destination.
- R6: Each beat reads the source address and then writes the data it read to the destination address.
- R7: The source and destination registers show the live addresses during a run, including while the engine waits between bursts.
- R8: Setting control A bit 30 stops the engine at the next beat boundary. It then issues no memory request and the addresses stay constant. Clearing the bit continues the run from the same point to the full length.
- R9: Writing 0 to control A bit 31 during a run aborts it. No further memory request or acknowledge follows, and the stop code stays 0.
- R10: A normal finish writes stop code 5 into control B bits 18:16 and clears control A bit 31. An error response on the memory bus stops the run at once, writes stop code 1 and clears control A bit 31.
- R11: `irq` is high when the stop code is 5 and control B bit 19 is 1, or when the stop code is 1 and control B bit 20 is 1. Writing zeros to bits 18:16 while idle lowers it.
- R12: While the channel runs, writes to the address registers and to control B are ignored. Writes to control A change only bits 31 and 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory access address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Access accepted and completed this cycle |
| mem_rdata | input | DW | Read data, valid with `mem_ready` |
| mem_err | input | 1 | Error response, valid with `mem_ready` |
| per_req | input | 1 | Peripheral asks for a burst |
| per_ack | output | 1 | Burst request taken |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach from the ports is a run parked between two bursts with its live addresses in mid-flight. The bench gets there by raising `per_req` for exactly the cycle of the first acknowledge and then dropping it. It then reads the address registers while the engine waits, and checks that no memory request is made. Pause is tested the same way: a long self-started run is paused at an arbitrary cycle. The bench then checks that the address has stopped on a whole beat and that writes to the address and control words are refused. After resume the run must finish at the full length. Abort and error stops are checked by counting bus activity after the stop.

// File: rtl/pdma_channel.sv
module pdma_channel #(
  parameter int RA_W = 5,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_err,
  input  logic            per_req,
  output logic            per_ack,
  output logic            irq
);
  localparam int CNT_W = 16;
  localparam int BT_W  = 4;
  localparam logic [RA_W-1:0] A_GLB = '0;
  localparam logic [RA_W-1:0] A_CA  = RA_W'(16);
  localparam logic [RA_W-1:0] A_CB  = RA_W'(20);
  localparam logic [RA_W-1:0] A_SA  = RA_W'(24);
  localparam logic [RA_W-1:0] A_DA  = RA_W'(28);
  localparam logic [2:0] STOP_DONE = 3'd5;
  localparam logic [2:0] STOP_ERR  = 3'd1;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_RD, S_WR, S_GAP} st_t;

  st_t              st_q;
  logic             gen_q;
  logic [31:0]      ca_q, cb_q;
  logic [AW-1:0]    sa_q, da_q;
  logic [DW-1:0]    data_q;
  logic [CNT_W-1:0] burst_left;
  logic [BT_W-1:0]  beat_left;
  logic [AW-1:0]    step;

  function automatic logic [BT_W-1:0] beats_m1(input logic [3:0] bt);
    case (bt)
      4'hF:    return BT_W'(15);
      4'hD:    return BT_W'(7);
      4'hB:    return BT_W'(3);
      default: return '0;
    endcase
  endfunction

  wire run   = ca_q[31];
  wire pause = ca_q[30];
  wire self  = ca_q[29];
  wire wr_g  = reg_we && reg_addr == A_GLB;
  wire wr_ca = reg_we && reg_addr == A_CA;
  wire wr_cb = reg_we && reg_addr == A_CB;
  wire wr_sa = reg_we && reg_addr == A_SA;
  wire wr_da = reg_we && reg_addr == A_DA;

  assign step      = (cb_q[27:26] == 2'd0) ? AW'(1) : (cb_q[27:26] == 2'd1) ? AW'(2) : AW'(4);
  assign mem_req   = st_q == S_RD || st_q == S_WR;
  assign mem_we    = st_q == S_WR;
  assign mem_addr  = (st_q == S_WR) ? da_q : sa_q;
  assign mem_wdata = data_q;
  assign per_ack   = st_q == S_ARM && !pause && !self && per_req;
  assign irq       = (cb_q[18:16] == STOP_DONE && cb_q[19]) || (cb_q[18:16] == STOP_ERR && cb_q[20]);

  always_comb begin
    case (reg_addr)
      A_GLB:   reg_rdata = {gen_q, 31'b0};
      A_CA:    reg_rdata = ca_q;
      A_CB:    reg_rdata = cb_q;
      A_SA:    reg_rdata = 32'(sa_q);
      A_DA:    reg_rdata = 32'(da_q);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      gen_q      <= 1'b0;
      ca_q       <= '0;
      cb_q       <= '0;
      sa_q       <= '0;
      da_q       <= '0;
      data_q     <= '0;
      burst_left <= '0;
      beat_left  <= '0;
    end else begin
      case (st_q)
        S_ARM: if (!pause && (per_req || self)) st_q <= S_RD;
        S_GAP: if (!pause) st_q <= S_RD;
        S_RD: if (mem_ready) begin
          if (mem_err) begin
            cb_q[18:16] <= STOP_ERR;
            ca_q[31]    <= 1'b0;
            st_q        <= S_IDLE;
          end else begin
            data_q <= mem_rdata;
            st_q   <= S_WR;
          end
        end
        S_WR: if (mem_ready) begin
          if (mem_err) begin
            cb_q[18:16] <= STOP_ERR;
            ca_q[31]    <= 1'b0;
            st_q        <= S_IDLE;
          end else begin
            if (!cb_q[25]) sa_q <= sa_q + step;
            if (!cb_q[24]) da_q <= da_q + step;
            if (beat_left != '0) begin
              beat_left <= beat_left - 1'b1;
              st_q      <= S_GAP;
            end else if (burst_left != '0) begin
              burst_left <= burst_left - 1'b1;
              beat_left  <= beats_m1(ca_q[23:20]);
              st_q       <= S_ARM;
            end else begin
              cb_q[18:16] <= STOP_DONE;
              ca_q[31]    <= 1'b0;
              st_q        <= S_IDLE;
            end
          end
        end
        default: ;
      endcase

      if (wr_g) gen_q <= reg_wdata[31];

      if (!run) begin
        if (wr_cb) cb_q <= reg_wdata;
        if (wr_sa) sa_q <= AW'(reg_wdata);
        if (wr_da) da_q <= AW'(reg_wdata);
        if (wr_ca) begin
          ca_q <= {reg_wdata[31] & gen_q, reg_wdata[30:0]};
          if (reg_wdata[31] && gen_q) begin
            st_q        <= S_ARM;
            cb_q[18:16] <= '0;
            burst_left  <= reg_wdata[CNT_W-1:0];
            beat_left   <= beats_m1(reg_wdata[23:20]);
          end
        end
      end else if (wr_ca) begin
        ca_q[30] <= reg_wdata[30];
        if (!reg_wdata[31]) begin
          ca_q[31] <= 1'b0;
          st_q     <= S_IDLE;
        end
      end
    end
  end

  p_ack_then_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> (mem_req && !mem_we) || !run);
  p_hold_on_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_ARM || st_q == S_GAP) && pause) |=> $stable(sa_q) && $stable(da_q));
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mem_req && !per_ack);
  p_stop_clears_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_q[18:16] != 3'd0) |-> !run);
  p_locked_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pause && st_q == S_ARM && wr_sa) |=> $stable(sa_q));
endmodule

// File: tb/tb_pdma_channel.sv
module tb_pdma_channel;
  localparam int PERIOD = 10;
  localparam logic [31:0] PER = 32'h800;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ready, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic per_req = 0, per_ack, irq;

  logic [31:0] mem [0:255];
  logic [31:0] pr_val, last_pw;
  int pw_cnt, ack_cnt;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  pdma_channel dut (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ready, .mem_rdata, .mem_err,
    .per_req, .per_ack, .irq);

  assign mem_ready = mem_req;
  assign mem_err   = mem_req && mem_addr >= 32'hF00;
  assign mem_rdata = (mem_addr == PER) ? pr_val : mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 + i;
      pr_val <= 32'h5000_0000; last_pw <= '0; pw_cnt <= 0; ack_cnt <= 0;
    end else begin
      if (per_ack) ack_cnt <= ack_cnt + 1;
      if (mem_req && mem_ready && !mem_err) begin
        if (mem_we) begin
          if (mem_addr == PER) begin pw_cnt <= pw_cnt + 1; last_pw <= mem_wdata; end
          else mem[mem_addr[9:2]] <= mem_wdata;
        end else if (mem_addr == PER) pr_val <= pr_val + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_stop();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(5'h10, v);
      if (!v[31]) return;
    end
    chk("R10 run bit never cleared", v, 32'h0);
  endtask

  task automatic go(input logic [31:0] sa, da, cb, ca);
    wr(5'h18, sa); wr(5'h1C, da); wr(5'h14, cb); wr(5'h10, ca);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      if (a == 0 || a >= 4) begin rd(5'(a * 4), v); chk("R1 reset value", v, 0); end
    end
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 no request after reset", {30'b0, mem_req, per_ack}, 0);
  endtask

  task automatic t_no_permit();
    logic [31:0] v;
    wr(5'h10, 32'h8000_0000);
    repeat (5) @(negedge clk);
    rd(5'h10, v); chk("R2 run bit without permit", v, 0);
    chk("R2 no request without permit", {31'b0, mem_req}, 0);
    wr(5'h00, 32'h8000_0000);
    rd(5'h00, v); chk("R1 global permit readback", v, 32'h8000_0000);
  endtask

  task automatic t_mem_to_dev();
    int p0, a0; logic [31:0] v;
    p0 = pw_cnt; a0 = ack_cnt; per_req = 1;
    go(32'h100, PER, 32'h0908_0000, 32'h80B0_0001);
    wait_stop(); per_req = 0;
    chk("R4 4-beat x2 bursts: peripheral writes", pw_cnt - p0, 8);
    chk("R3 one ack per burst", ack_cnt - a0, 2);
    chk("R6 last data to peripheral", last_pw, 32'hA000_0047);
    rd(5'h18, v); chk("R5 source stepped by 4", v, 32'h120);
    rd(5'h1C, v); chk("R5 destination held", v, PER);
    rd(5'h14, v); chk("R10 completion code", v, 32'h090D_0000);
    chk("R11 irq on completion", {31'b0, irq}, 1);
  endtask

  task automatic t_dev_to_mem();
    logic [31:0] v, p; int a0;
    p = pr_val; a0 = ack_cnt; per_req = 1;
    go(PER, 32'h200, 32'h0608_0000, 32'h8000_0002);
    wait_stop(); per_req = 0;
    rd(5'h1C, v); chk("R5 2-byte step, single beats x3", v, 32'h206);
    rd(5'h18, v); chk("R5 source held", v, PER);
    chk("R4 single-beat bursts: acks", ack_cnt - a0, 3);
    chk("R6 third read lands at 0x204", mem[8'h81], p + 2);
  endtask

  task automatic t_byte16();
    int p0, a0; logic [31:0] v;
    p0 = pw_cnt; a0 = ack_cnt; per_req = 1;
    go(32'h300, PER, 32'h0108_0000, 32'h80F0_0000);
    wait_stop(); per_req = 0;
    chk("R4 16-beat burst writes", pw_cnt - p0, 16);
    chk("R4 16-beat burst acks", ack_cnt - a0, 1);
    rd(5'h18, v); chk("R5 1-byte step", v, 32'h310);
  endtask

  task automatic t_self8();
    int a0; logic [31:0] v;
    a0 = ack_cnt;
    go(32'h000, 32'h380, 32'h0808_0000, 32'hA0D0_0000);
    wait_stop();
    chk("R3 self-start gives no ack", ack_cnt - a0, 0);
    rd(5'h18, v); chk("R4 8-beat source end", v, 32'h20);
    rd(5'h1C, v); chk("R4 8-beat destination end", v, 32'h3A0);
    chk("R6 memory copy last word", mem[8'hE7], 32'hA000_0007);
  endtask

  task automatic t_gap();
    logic [31:0] v;
    per_req = 1;
    go(32'h040, PER, 32'h0908_0000, 32'h80B0_0001);
    @(negedge clk); per_req = 0;
    repeat (30) @(negedge clk);
    rd(5'h18, v); chk("R7 live source between bursts", v, 32'h050);
    chk("R3 no access while waiting", {31'b0, mem_req}, 0);
    wr(5'h18, 32'h123);
    rd(5'h18, v); chk("R12 address write ignored", v, 32'h050);
    per_req = 1; wait_stop(); per_req = 0;
    rd(5'h18, v); chk("R7 source after second burst", v, 32'h060);
  endtask

  task automatic t_pause();
    logic [31:0] s1, v;
    go(32'h000, 32'h200, 32'h0808_0000, 32'hA0F0_0000);
    repeat (5) @(negedge clk);
    wr(5'h10, 32'hE000_0000);
    repeat (3) @(negedge clk);
    rd(5'h18, s1);
    repeat (10) @(negedge clk);
    rd(5'h18, v); chk("R8 address frozen in pause", v, s1);
    chk("R8 no request in pause", {31'b0, mem_req}, 0);
    chk("R8 stopped on a beat", {30'b0, s1[1:0]}, 0);
    wr(5'h14, 32'h0);
    rd(5'h14, v); chk("R12 control B write ignored", v, 32'h0808_0000);
    wr(5'h10, 32'hA000_0000);
    wait_stop();
    rd(5'h18, v); chk("R8 full length after resume", v, 32'h40);
  endtask

  task automatic t_abort();
    logic [31:0] v; int p0;
    go(32'h000, PER, 32'h0908_0000, 32'hA0F0_0003);
    repeat (10) @(negedge clk);
    wr(5'h10, 32'h0);
    repeat (2) @(negedge clk);
    p0 = pw_cnt;
    repeat (20) @(negedge clk);
    chk("R9 no writes after abort", pw_cnt - p0, 0);
    chk("R9 no request after abort", {31'b0, mem_req}, 0);
    rd(5'h14, v); chk("R9 stop code stays 0", v, 32'h0908_0000);
    chk("R9 irq low after abort", {31'b0, irq}, 0);
  endtask

  task automatic t_error();
    logic [31:0] v;
    go(32'hF00, 32'h200, 32'h0818_0000, 32'hA000_0000);
    wait_stop();
    rd(5'h14, v); chk("R10 error code", v, 32'h0819_0000);
    chk("R11 irq on error", {31'b0, irq}, 1);
    wr(5'h14, 32'h0818_0000);
    chk("R11 irq cleared by zero write", {31'b0, irq}, 0);
  endtask

  task automatic t_masked();
    logic [31:0] v;
    go(32'h000, 32'h3F0, 32'h0800_0000, 32'hA000_0000);
    wait_stop();
    rd(5'h14, v); chk("R10 completion code masked", v, 32'h0805_0000);
    chk("R11 masked completion irq", {31'b0, irq}, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_no_permit(); t_mem_to_dev(); t_dev_to_mem(); t_byte16();
    t_self8(); t_gap(); t_pause(); t_abort(); t_error(); t_masked();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule